// File: doc/BRIEF.md
# Strict Signature Verification Sequencer

This block runs the control side of a strict Edwards-curve signature check. It takes a command carrying the scalar half S of a signature, the 32-byte encoding of the commitment point R, and two status flags for problems found before it started. It then runs the rejection checks in a fixed order, so that a bad signature is always turned away by its earliest fault.

The block only does two pieces of the math itself. It checks that S lies below the group order l, and it compares two 32-byte encodings in constant time. Point decoding, the challenge hash and the double scalar multiply are done by outside engines. The block drives each of these with a request level and reads back a done strobe plus error flags. Each command ends with one 4-bit result code, shown for a single cycle.

Top module: `sigverify_seq`

## Requirements
- R1: While reset is held and after it is released, the block shows `cmd_ready` high, `res_valid` low and no engine request.
- R2: A command with `cmd_frame_err` set finishes with code 1 and raises no engine request. This holds even if `cmd_no_key` is also set.
- R3: A command with only `cmd_no_key` set finishes with code 2 and raises no engine request.
- R4: S, read as a little-endian 256-bit integer, counts as canonical only when it is strictly less than l = 2^252 + 27742317777372353535851937790883648493. The compare covers every byte. A non-canonical S finishes with code 3 and no decode is requested.
- R5: The first decode request has `dec_sel`=0 (point A). On its done strobe, malformed ends with code 4 and small-order ends with code 5. If both flags are set, malformed takes precedence.
- R6: The second decode request has `dec_sel`=1 (point R). Malformed ends with code 6 and small-order ends with code 7.
- R7: The hash is requested only after both decodes pass. A hash error ends with code 8.
- R8: The scalar multiply is requested only after the hash completes without error. A multiply error ends with code 8.
- R9: The product encoding is compared with R over all 256 bits. A difference in any single bit gives code 8; a full match gives code 0.
- R10: `res_valid` is high for exactly one cycle per command, with the code shown on `res_code`. `cmd_ready` is high only when the block is idle, and a `cmd_start` while it is busy has no effect.
- R11: At most one engine request is high at a time. Each request stays high, with a stable `dec_sel`, until its done strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start a verification (taken only when idle) |
| cmd_frame_err | input | 1 | The command stream was framed badly |
| cmd_no_key | input | 1 | No cached public key is present |
| cmd_s | input | 256 | Scalar S, little-endian |
| cmd_r_enc | input | 256 | Encoded commitment point R |
| cmd_ready | output | 1 | High when idle |
| dec_req | output | 1 | Point decode request (level) |
| dec_sel | output | 1 | Decode target: 0 = A, 1 = R |
| dec_done | input | 1 | Decode finished |
| dec_malformed | input | 1 | The decoded point is malformed |
| dec_small_order | input | 1 | The decoded point has small order |
| hash_req | output | 1 | Challenge hash request (level) |
| hash_done | input | 1 | Hash finished |
| hash_err | input | 1 | The hash engine reported an error |
| smul_req | output | 1 | Scalar multiply request (level) |
| smul_done | input | 1 | Multiply finished |
| smul_err | input | 1 | The multiply engine reported an error |
| smul_enc | input | 256 | Encoding of [S]B - [k]A, valid with smul_done |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 4 | Result code (0 = valid ... 8 = equation failure) |

## Verification
The equality compare is reached only after every earlier stage has passed. A test aimed at it therefore has to pass through two clean decodes, a clean hash and a clean multiply. The bench engine model answers each request after a fixed latency with flags taken from the current vector. The multiply answer is the stored R with one chosen bit flipped: the lowest bit, the top bit, or a middle bit. That shows the compare looks at all 32 bytes. The S values sit right at l-1, l, l+1, 2^252 and all-ones, so the byte-wise range check is decided at different byte positions.

// File: rtl/sigverify_pkg.sv
package sigverify_pkg;
  localparam int unsigned SIG_BYTES = 32;
  localparam int unsigned SIG_BITS  = 8 * SIG_BYTES;
  localparam int unsigned CODE_W    = 4;

  // Prime order of the base-point subgroup, little-endian value.
  localparam logic [SIG_BITS-1:0] GROUP_ORDER =
    256'h1000000000000000000000000000000014def9dea2f79cd65812631a5cf5d3ed;

  typedef enum logic [CODE_W-1:0] {
    RC_OK      = 4'd0,
    RC_FRAME   = 4'd1,
    RC_NOKEY   = 4'd2,
    RC_S_RANGE = 4'd3,
    RC_A_BAD   = 4'd4,
    RC_A_SMALL = 4'd5,
    RC_R_BAD   = 4'd6,
    RC_R_SMALL = 4'd7,
    RC_EQN     = 4'd8
  } rc_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHK_S, ST_DEC_A, ST_DEC_R, ST_HASH, ST_SMUL, ST_CMP, ST_DONE
  } st_t;
endpackage

// File: rtl/sv_rst_sync.sv
module sv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/sv_canon_check.sv
// Byte-serial magnitude compare from the top byte down, every byte evaluated.
module sv_canon_check #(
  parameter int unsigned NB = 32
) (
  input  logic [8*NB-1:0] value,
  input  logic [8*NB-1:0] bound,
  output logic            below
);
  logic [NB-1:0] byte_lt;
  logic [NB-1:0] byte_eq;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign byte_lt[g] = value[8*g +: 8] < bound[8*g +: 8];
    assign byte_eq[g] = value[8*g +: 8] == bound[8*g +: 8];
  end

  always_comb begin
    logic lt_acc;
    logic eq_acc;
    lt_acc = 1'b0;
    eq_acc = 1'b1;
    for (int i = NB - 1; i >= 0; i--) begin
      lt_acc = lt_acc | (eq_acc & byte_lt[i]);
      eq_acc = eq_acc & byte_eq[i];
    end
    below = lt_acc;
  end
endmodule

// File: rtl/sv_bytes_eq.sv
// OR of every byte-pair XOR: no early exit, fixed depth.
module sv_bytes_eq #(
  parameter int unsigned NB = 32
) (
  input  logic [8*NB-1:0] lhs,
  input  logic [8*NB-1:0] rhs,
  output logic            equal
);
  logic [NB-1:0] byte_diff;

  for (genvar g = 0; g < NB; g++) begin : g_pair
    assign byte_diff[g] = |(lhs[8*g +: 8] ^ rhs[8*g +: 8]);
  end

  assign equal = ~|byte_diff;
endmodule

// File: rtl/sv_seq_ctrl.sv
module sv_seq_ctrl
  import sigverify_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_frame_err,
  input  logic              cmd_no_key,
  input  logic              s_ok,
  input  logic              dec_done,
  input  logic              dec_malformed,
  input  logic              dec_small_order,
  input  logic              hash_done,
  input  logic              hash_err,
  input  logic              smul_done,
  input  logic              smul_err,
  input  logic              enc_equal,
  output logic              cmd_ready,
  output logic              load_cmd,
  output logic              load_pt,
  output logic              dec_req,
  output logic              dec_sel,
  output logic              hash_req,
  output logic              smul_req,
  output logic              res_valid,
  output logic [CODE_W-1:0] res_code,
  output st_t               st
);
  st_t st_q, st_d;
  rc_t code_q, code_d;
  logic code_en;

  always_comb begin
    st_d    = st_q;
    code_d  = code_q;
    code_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (cmd_start) begin
        if (cmd_frame_err) begin
          code_d = RC_FRAME; code_en = 1'b1; st_d = ST_DONE;
        end else if (cmd_no_key) begin
          code_d = RC_NOKEY; code_en = 1'b1; st_d = ST_DONE;
        end else begin
          st_d = ST_CHK_S;
        end
      end
      ST_CHK_S: begin
        if (!s_ok) begin
          code_d = RC_S_RANGE; code_en = 1'b1; st_d = ST_DONE;
        end else begin
          st_d = ST_DEC_A;
        end
      end
      ST_DEC_A: if (dec_done) begin
        if (dec_malformed) begin
          code_d = RC_A_BAD; code_en = 1'b1; st_d = ST_DONE;
        end else if (dec_small_order) begin
          code_d = RC_A_SMALL; code_en = 1'b1; st_d = ST_DONE;
        end else begin
          st_d = ST_DEC_R;
        end
      end
      ST_DEC_R: if (dec_done) begin
        if (dec_malformed) begin
          code_d = RC_R_BAD; code_en = 1'b1; st_d = ST_DONE;
        end else if (dec_small_order) begin
          code_d = RC_R_SMALL; code_en = 1'b1; st_d = ST_DONE;
        end else begin
          st_d = ST_HASH;
        end
      end
      ST_HASH: if (hash_done) begin
        if (hash_err) begin
          code_d = RC_EQN; code_en = 1'b1; st_d = ST_DONE;
        end else begin
          st_d = ST_SMUL;
        end
      end
      ST_SMUL: if (smul_done) begin
        if (smul_err) begin
          code_d = RC_EQN; code_en = 1'b1; st_d = ST_DONE;
        end else begin
          st_d = ST_CMP;
        end
      end
      ST_CMP: begin
        code_d  = enc_equal ? RC_OK : RC_EQN;
        code_en = 1'b1;
        st_d    = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      code_q <= RC_OK;
    end else begin
      st_q <= st_d;
      if (code_en) code_q <= code_d;
    end
  end

  assign cmd_ready = (st_q == ST_IDLE);
  assign load_cmd  = (st_q == ST_IDLE) & cmd_start & ~cmd_frame_err & ~cmd_no_key;
  assign load_pt   = (st_q == ST_SMUL) & smul_done & ~smul_err;
  assign dec_req   = (st_q == ST_DEC_A) | (st_q == ST_DEC_R);
  assign dec_sel   = (st_q == ST_DEC_R);
  assign hash_req  = (st_q == ST_HASH);
  assign smul_req  = (st_q == ST_SMUL);
  assign res_valid = (st_q == ST_DONE);
  assign res_code  = code_q;
  assign st        = st_q;
endmodule

// File: rtl/sigverify_seq.sv
module sigverify_seq
  import sigverify_pkg::*;
#(
  parameter int unsigned NB = SIG_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_frame_err,
  input  logic              cmd_no_key,
  input  logic [8*NB-1:0]   cmd_s,
  input  logic [8*NB-1:0]   cmd_r_enc,
  output logic              cmd_ready,
  output logic              dec_req,
  output logic              dec_sel,
  input  logic              dec_done,
  input  logic              dec_malformed,
  input  logic              dec_small_order,
  output logic              hash_req,
  input  logic              hash_done,
  input  logic              hash_err,
  output logic              smul_req,
  input  logic              smul_done,
  input  logic              smul_err,
  input  logic [8*NB-1:0]   smul_enc,
  output logic              res_valid,
  output logic [CODE_W-1:0] res_code
);
  localparam int unsigned W = 8 * NB;

  logic         rst_n_i;
  logic         load_cmd, load_pt, s_ok, enc_equal;
  logic [W-1:0] s_q, r_q, pt_q;
  st_t          ctrl_st;

  sv_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      s_q  <= '0;
      r_q  <= '0;
      pt_q <= '0;
    end else begin
      if (load_cmd) begin
        s_q <= cmd_s;
        r_q <= cmd_r_enc;
      end
      if (load_pt) pt_q <= smul_enc;
    end
  end

  sv_canon_check #(.NB(NB)) u_canon (
    .value(s_q), .bound(GROUP_ORDER[W-1:0]), .below(s_ok)
  );

  sv_bytes_eq #(.NB(NB)) u_eq (.lhs(r_q), .rhs(pt_q), .equal(enc_equal));

  sv_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_i),
    .cmd_start(cmd_start), .cmd_frame_err(cmd_frame_err), .cmd_no_key(cmd_no_key),
    .s_ok(s_ok),
    .dec_done(dec_done), .dec_malformed(dec_malformed), .dec_small_order(dec_small_order),
    .hash_done(hash_done), .hash_err(hash_err),
    .smul_done(smul_done), .smul_err(smul_err),
    .enc_equal(enc_equal),
    .cmd_ready(cmd_ready), .load_cmd(load_cmd), .load_pt(load_pt),
    .dec_req(dec_req), .dec_sel(dec_sel), .hash_req(hash_req), .smul_req(smul_req),
    .res_valid(res_valid), .res_code(res_code), .st(ctrl_st)
  );
endmodule

// File: rtl/sigverify_seq_chk.sv
module sigverify_seq_chk
  import sigverify_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              dec_req,
  input logic              dec_sel,
  input logic              dec_done,
  input logic              hash_req,
  input logic              hash_done,
  input logic              smul_req,
  input logic              res_valid,
  input logic [CODE_W-1:0] res_code,
  input st_t               st
);
  // R10: one-cycle result strobe
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R10: code within the defined set
  a_r10_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_code <= 4'd8));
  // R10: not ready while reporting
  a_r10_busy_report: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !cmd_ready);
  // R11: one request at a time
  a_r11_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_req, hash_req, smul_req}));
  // R11: decode request held until done
  a_r11_dec_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !dec_done) |=> (dec_req && $stable(dec_sel)));
  // R4: decode of A begins only after the S range check
  a_r4_canon_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dec_req) && !dec_sel) |-> $past(st == ST_CHK_S));
  // R7: hash follows a completed R decode
  a_r7_hash_after_r: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hash_req) |-> $past(dec_req && dec_sel && dec_done));
  // R8: multiply follows a completed hash
  a_r8_smul_after_hash: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smul_req) |-> $past(hash_req && hash_done));
endmodule

bind sigverify_seq sigverify_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
  .dec_req(dec_req), .dec_sel(dec_sel), .dec_done(dec_done),
  .hash_req(hash_req), .hash_done(hash_done), .smul_req(smul_req),
  .res_valid(res_valid), .res_code(res_code), .st(ctrl_st)
);

// File: tb/sigverify_seq_test.sv
module sigverify_seq_test;
  import sigverify_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;
  localparam logic [255:0] L = GROUP_ORDER;
  localparam logic [255:0] R_ENC = 256'h5a17c3e9_0b42d8f6_7e91a03c_24d6b58f_c1e07a93_6f2b48d5_9a03e7c1_b4f65d28;

  typedef struct packed {
    logic frame; logic nokey; logic [255:0] s;
    logic a_bad; logic a_small; logic r_bad; logic r_small;
    logic h_err; logic m_err; logic mis; logic [7:0] flip;
    logic [3:0] code; logic [3:0] mask;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,256'h5,   1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'd0,  4'd1,4'h0}, // R2
    '{1'b0,1'b1,256'h5,   1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'd0,  4'd2,4'h0}, // R3
    '{1'b0,1'b0,L,        1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'd0,  4'd3,4'h0}, // R4
    '{1'b0,1'b0,L+256'd1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'd0,  4'd3,4'h0}, // R4
    '{1'b0,1'b0,{256{1'b1}},1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'd0,4'd3,4'h0}, // R4
    '{1'b0,1'b0,L-256'd1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'd0,  4'd0,4'hF}, // R4 R9
    '{1'b0,1'b0,256'd0,   1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'd0,  4'd0,4'hF}, // R4
    '{1'b0,1'b0,256'd1<<252,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'd0,4'd0,4'hF}, // R4
    '{1'b0,1'b0,256'h5,   1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'd0,  4'd4,4'h1}, // R5
    '{1'b0,1'b0,256'h5,   1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'd0,  4'd4,4'h1}, // R5
    '{1'b0,1'b0,256'h5,   1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'd0,  4'd5,4'h1}, // R5
    '{1'b0,1'b0,256'h5,   1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'd0,  4'd6,4'h3}, // R6
    '{1'b0,1'b0,256'h5,   1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd0,  4'd7,4'h3}, // R6
    '{1'b0,1'b0,256'h5,   1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'd0,  4'd8,4'h7}, // R7
    '{1'b0,1'b0,256'h5,   1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'd0,  4'd8,4'hF}, // R8
    '{1'b0,1'b0,256'h5,   1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'd0,  4'd8,4'hF}, // R9
    '{1'b0,1'b0,256'h5,   1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'd255,4'd8,4'hF}, // R9
    '{1'b0,1'b0,256'h5,   1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'd130,4'd8,4'hF}  // R9
  };

  logic clk, rst_n;
  logic cmd_start, cmd_frame_err, cmd_no_key;
  logic [255:0] cmd_s, cmd_r_enc, smul_enc;
  logic cmd_ready, dec_req, dec_sel, dec_done, dec_malformed, dec_small_order;
  logic hash_req, hash_done, hash_err, smul_req, smul_done, smul_err;
  logic res_valid;
  logic [3:0] res_code;

  int checks = 0, failures = 0, excl_viol = 0;
  logic [3:0] served;
  vec_t cur;
  bit finished = 0;

  sigverify_seq uut (.*);

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Engine model: answers each request LAT cycles after it appears.
  initial begin
    int lat;
    lat = 0;
    dec_done = 0; dec_malformed = 0; dec_small_order = 0;
    hash_done = 0; hash_err = 0; smul_done = 0; smul_err = 0; smul_enc = '0;
    served = '0;
    forever begin
      @(negedge clk);
      if (($countones({dec_req, hash_req, smul_req})) > 1) excl_viol++;
      dec_done = 0; hash_done = 0; smul_done = 0;
      if (dec_req || hash_req || smul_req) begin
        if (lat == LAT) begin
          lat = 0;
          if (dec_req) begin
            dec_done = 1;
            dec_malformed   = dec_sel ? cur.r_bad   : cur.a_bad;
            dec_small_order = dec_sel ? cur.r_small : cur.a_small;
            served[dec_sel ? 1 : 0] = 1'b1;
          end else if (hash_req) begin
            hash_done = 1; hash_err = cur.h_err; served[2] = 1'b1;
          end else begin
            smul_done = 1; smul_err = cur.m_err; served[3] = 1'b1;
            smul_enc = cur.mis ? (R_ENC ^ (256'd1 << cur.flip)) : R_ENC;
          end
        end else lat++;
      end else lat = 0;
    end
  end

  task automatic run_cmd(input vec_t v, input int idx, input bit poke_busy);
    bit got;
    cur = v;
    served = '0;
    @(negedge clk);
    cmd_frame_err = v.frame; cmd_no_key = v.nokey; cmd_s = v.s; cmd_r_enc = R_ENC;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0; cmd_frame_err = 1'b0; cmd_no_key = 1'b0;
    if (poke_busy) begin
      @(negedge clk);
      check("R10 busy ready", cmd_ready, 1'b0);
      cmd_start = 1'b1; cmd_frame_err = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0; cmd_frame_err = 1'b0;
    end
    got = 0;
    for (int t = 0; t < 200 && !got; t++) begin
      if (res_valid) got = 1; else @(negedge clk);
    end
    check($sformatf("vec%0d R10 result seen", idx), got, 1'b1);
    check($sformatf("vec%0d R2-R9 code", idx), res_code, v.code);
    check($sformatf("vec%0d R5 R7 R8 engines used", idx), served, v.mask);
    @(negedge clk);
    check($sformatf("vec%0d R10 pulse width", idx), res_valid, 1'b0);
    check($sformatf("vec%0d R10 ready after", idx), cmd_ready, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    vec_t vb;
    rst_n = 1'b0; cmd_start = 0; cmd_frame_err = 0; cmd_no_key = 0;
    cmd_s = '0; cmd_r_enc = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 ready in reset", cmd_ready, 1'b1);
    check("R1 no result in reset", res_valid, 1'b0);
    check("R1 no request in reset", {dec_req, hash_req, smul_req}, 3'b000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready after reset", cmd_ready, 1'b1);
    check("R1 idle requests", {dec_req, hash_req, smul_req, res_valid}, 4'b0000);

    for (int i = 0; i < NV; i++) run_cmd(VECS[i], i, 1'b0);

    // R10: a start while busy (with a framing flag) must not alter the outcome
    vb = VECS[6];
    run_cmd(vb, 100, 1'b1);

    // R1: reset in the middle of an operation returns to idle
    cur = VECS[6];
    @(negedge clk);
    cmd_s = 256'h5; cmd_r_enc = R_ENC; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-op reset ready", cmd_ready, 1'b1);
    check("R1 mid-op reset requests", {dec_req, hash_req, smul_req}, 3'b000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_cmd(VECS[15], 101, 1'b0);

    check("R11 request exclusivity", excl_viol, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule